// File: doc/BRIEF.md
# CCD Horizontal Readout Clock Generator

This block drives the horizontal shift register of an interline CCD during line readout. For each of up to four output quadrants it produces the phase-1 storage and barrier clocks, the phase-2 storage and barrier clocks, and a separately driven phase-2 last-gate clock. It also produces a reset-gate pulse inside every pixel period. For the video digitizer it emits two one-cycle strobes per pixel: one on the reset level and one on the video level, for correlated double sampling.

The vertical sequencer pulses a line request once the line shift is complete. The block captures the line settings on that cycle and waits a programmed delay, never shorter than a minimum settling time. It then clocks out the programmed number of pixels and pulses line-done. The pixel period, the reset width and both strobe positions are counted in ticks of the block clock. A per-quadrant enable selects the readout mode. A build-time choice decides whether a disabled quadrant is parked with all of its gates low or keeps being clocked.

Top module: `hclk_gen`

## Requirements
- R1: After reset, every enabled quadrant is at the idle phase: phase-1 storage and barrier are 1, and phase-2 storage, barrier, last gate and reset gate are 0. Both strobes and line-done are 0.
- R2: A line request seen while idle with a nonzero pixel count captures all settings. Let D be the larger of start_delay and MIN_START_TICKS (default 250, which is 1 us at 250 MHz). Tick 0 of the first pixel appears at the outputs D+1 cycles after the clock edge that samples the request. Until then the clocks hold the idle phase.
- R3: Each pixel lasts P ticks. Phase-1 storage and barrier are 1 for ticks 0 to floor(P/2)-1 and 0 for the rest of the pixel. Phase-2 storage, barrier and last gate are the complement of phase 1. The last gate therefore falls at the start of each following pixel.
- R4: P is the larger of pix_period and MIN_PERIOD_TICKS (default 7 ticks, which is 28 ns).
- R5: The reset gate is 1 for ticks 0 to W-1 of every pixel. W is rst_width clamped into the range 1 to P-1.
- R6: samp_rst is 1 for exactly the tick equal to samp_rst_ofs, and samp_vid for exactly the tick equal to samp_vid_ofs, once in each pixel. An offset of P or more gives no strobe.
- R7: Exactly pix_count pixels are clocked. In the cycle after the last tick, every clock is back at the idle phase and line_done is 1 for that single cycle.
- R8: A line request with pix_count equal to 0 is ignored. The clocks stay idle and line_done stays 0.
- R9: A line request that arrives while a line is waiting or running is ignored. The line in progress keeps its pixel count and timing.
- R10: With PARK_UNUSED=1 (the default), a quadrant whose quad_en bit is 0 drives all six of its outputs to 0 from one cycle after that bit is seen. Enabled quadrants are unaffected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Tick clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| line_req | input | 1 | Line start request from the vertical sequencer |
| quad_en | input | NUM_QUAD | Readout mode: 1 = quadrant clocked |
| start_delay | input | DLY_W | Ticks from request to first pixel |
| pix_count | input | PIX_W | Pixels per line |
| pix_period | input | TICK_W | Ticks per pixel |
| rst_width | input | TICK_W | Reset-gate width in ticks |
| samp_rst_ofs | input | TICK_W | Tick of the reset-level strobe |
| samp_vid_ofs | input | TICK_W | Tick of the video-level strobe |
| h1_stor | output | NUM_QUAD | Phase-1 storage clock per quadrant |
| h1_barr | output | NUM_QUAD | Phase-1 barrier clock per quadrant |
| h2_stor | output | NUM_QUAD | Phase-2 storage clock per quadrant |
| h2_barr | output | NUM_QUAD | Phase-2 barrier clock per quadrant |
| h2_last | output | NUM_QUAD | Phase-2 last-gate clock per quadrant |
| reset_gate | output | NUM_QUAD | Reset-gate pulse per quadrant |
| samp_rst | output | 1 | Reset-level sample strobe |
| samp_vid | output | 1 | Video-level sample strobe |
| line_done | output | 1 | One-cycle end-of-line pulse |

## Verification
Every output sits one register behind the sequencer. Pixel tick t of a line is therefore due D+1+t edges after the edge that samples the request, and line_done is due at edge D+1+N*P. After that edge the driver pushes one expected output vector per cycle, starting with the one for that same edge. The monitor pops one vector at each falling edge, so every comparison happens half a cycle after the output settles and each queue entry lines up with exactly one edge. Requests that must be ignored are issued while the queue still holds the expected vectors of the line in progress, so a restart or an extra pixel shows up as a miscompare.

// File: rtl/hclk_pkg.sv
package hclk_pkg;

    typedef enum logic [1:0] {
        SEQ_IDLE = 2'd0,
        SEQ_WAIT = 2'd1,
        SEQ_RUN  = 2'd2
    } seq_state_e;

    typedef struct packed {
        logic h1s;
        logic h1b;
        logic h2s;
        logic h2b;
        logic h2l;
        logic rg;
    } quad_out_t;

    localparam quad_out_t QUAD_IDLE = '{h1s: 1'b1, h1b: 1'b1, h2s: 1'b0,
                                        h2b: 1'b0, h2l: 1'b0, rg: 1'b0};
    localparam quad_out_t QUAD_OFF  = '{default: 1'b0};

endpackage

// File: rtl/hclk_seq.sv
module hclk_seq
    import hclk_pkg::*;
#(
    parameter int TICK_W           = 8,
    parameter int PIX_W            = 14,
    parameter int DLY_W            = 16,
    parameter int MIN_START_TICKS  = 250,
    parameter int MIN_PERIOD_TICKS = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              line_req,
    input  logic [DLY_W-1:0]  start_delay,
    input  logic [PIX_W-1:0]  pix_count,
    input  logic [TICK_W-1:0] pix_period,
    input  logic [TICK_W-1:0] rst_width,
    input  logic [TICK_W-1:0] samp_rst_ofs,
    input  logic [TICK_W-1:0] samp_vid_ofs,
    output logic              run,
    output logic [TICK_W-1:0] tick,
    output logic [TICK_W-1:0] per,
    output logic [TICK_W-1:0] rw,
    output logic [TICK_W-1:0] srst,
    output logic [TICK_W-1:0] svid,
    output logic              done
);

    localparam logic [DLY_W-1:0]  MIN_DLY_L = DLY_W'(MIN_START_TICKS);
    localparam logic [TICK_W-1:0] MIN_PER_L = TICK_W'(MIN_PERIOD_TICKS);

    typedef struct packed {
        seq_state_e        state;
        logic [DLY_W-1:0]  dly;
        logic [PIX_W-1:0]  pix;
        logic [TICK_W-1:0] tick;
        logic [TICK_W-1:0] per;
        logic [TICK_W-1:0] rw;
        logic [TICK_W-1:0] srst;
        logic [TICK_W-1:0] svid;
        logic              done;
    } seq_t;

    seq_t s_d, s_q;
    logic [TICK_W-1:0] per_c;
    logic [TICK_W-1:0] rw_c;

    always_comb begin
        s_d      = s_q;
        s_d.done = 1'b0;
        per_c    = (pix_period < MIN_PER_L) ? MIN_PER_L : pix_period;
        if (rst_width == '0) begin
            rw_c = TICK_W'(1);
        end else if (rst_width >= per_c) begin
            rw_c = per_c - TICK_W'(1);
        end else begin
            rw_c = rst_width;
        end
        unique case (s_q.state)
            SEQ_IDLE: begin
                if (line_req && (pix_count != '0)) begin
                    s_d.state = SEQ_WAIT;
                    s_d.dly   = (start_delay < MIN_DLY_L) ? MIN_DLY_L : start_delay;
                    s_d.pix   = pix_count;
                    s_d.per   = per_c;
                    s_d.rw    = rw_c;
                    s_d.srst  = samp_rst_ofs;
                    s_d.svid  = samp_vid_ofs;
                end
            end
            SEQ_WAIT: begin
                if (s_q.dly <= DLY_W'(1)) begin
                    s_d.state = SEQ_RUN;
                    s_d.tick  = '0;
                end else begin
                    s_d.dly = s_q.dly - DLY_W'(1);
                end
            end
            SEQ_RUN: begin
                if (s_q.tick == s_q.per - TICK_W'(1)) begin
                    s_d.tick = '0;
                    if (s_q.pix == PIX_W'(1)) begin
                        s_d.state = SEQ_IDLE;
                        s_d.done  = 1'b1;
                    end else begin
                        s_d.pix = s_q.pix - PIX_W'(1);
                    end
                end else begin
                    s_d.tick = s_q.tick + TICK_W'(1);
                end
            end
            default: s_d.state = SEQ_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign run  = (s_q.state == SEQ_RUN);
    assign tick = s_q.tick;
    assign per  = s_q.per;
    assign rw   = s_q.rw;
    assign srst = s_q.srst;
    assign svid = s_q.svid;
    assign done = s_q.done;

    assert_tick_in_period_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.state == SEQ_RUN) |-> ((s_q.tick < s_q.per) && (s_q.per >= MIN_PER_L)));

    assert_run_pix_nonzero_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.state == SEQ_RUN) |-> (s_q.pix != '0));

    assert_cfg_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.state != SEQ_IDLE) |=> ($stable(s_q.per) && $stable(s_q.rw)
                                     && $stable(s_q.srst) && $stable(s_q.svid)));

endmodule

// File: rtl/hclk_phase.sv
module hclk_phase #(
    parameter int TICK_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic [TICK_W-1:0] tick,
    input  logic [TICK_W-1:0] per,
    input  logic [TICK_W-1:0] rw,
    input  logic [TICK_W-1:0] srst,
    input  logic [TICK_W-1:0] svid,
    input  logic              done_in,
    output logic              h1_pat,
    output logic              h2_pat,
    output logic              rg_pat,
    output logic              samp_rst,
    output logic              samp_vid,
    output logic              line_done
);

    typedef struct packed {
        logic s_rst;
        logic s_vid;
        logic done;
    } strobe_t;

    strobe_t st_d, st_q;
    logic [TICK_W-1:0] half;
    logic              first_half;

    always_comb begin
        half       = per >> 1;
        first_half = (tick < half);
        h1_pat     = run ? first_half : 1'b1;
        h2_pat     = run ? !first_half : 1'b0;
        rg_pat     = run && (tick < rw);
        st_d.s_rst = run && (tick == srst);
        st_d.s_vid = run && (tick == svid);
        st_d.done  = done_in;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign samp_rst  = st_q.s_rst;
    assign samp_vid  = st_q.s_vid;
    assign line_done = st_q.done;

    assert_done_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
        line_done |=> !line_done);

endmodule

// File: rtl/hclk_quad.sv
module hclk_quad
    import hclk_pkg::*;
#(
    parameter bit PARK_UNUSED = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic h1_pat,
    input  logic h2_pat,
    input  logic rg_pat,
    output logic h1s,
    output logic h1b,
    output logic h2s,
    output logic h2b,
    output logic h2l,
    output logic rg
);

    quad_out_t o_d, o_q;

    always_comb begin
        if (PARK_UNUSED && !en) begin
            o_d = QUAD_OFF;
        end else begin
            o_d.h1s = h1_pat;
            o_d.h1b = h1_pat;
            o_d.h2s = h2_pat;
            o_d.h2b = h2_pat;
            o_d.h2l = h2_pat;
            o_d.rg  = rg_pat;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            o_q <= QUAD_IDLE;
        end else begin
            o_q <= o_d;
        end
    end

    assign h1s = o_q.h1s;
    assign h1b = o_q.h1b;
    assign h2s = o_q.h2s;
    assign h2b = o_q.h2b;
    assign h2l = o_q.h2l;
    assign rg  = o_q.rg;

    assert_no_phase_overlap_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (o_q.h1s || o_q.h1b) |-> !(o_q.h2s || o_q.h2b || o_q.h2l));

    assert_park_off_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (PARK_UNUSED && !en) |=> (o_q == QUAD_OFF));

endmodule

// File: rtl/hclk_gen.sv
module hclk_gen
    import hclk_pkg::*;
#(
    parameter int NUM_QUAD         = 4,
    parameter int TICK_W           = 8,
    parameter int PIX_W            = 14,
    parameter int DLY_W            = 16,
    parameter int MIN_START_TICKS  = 250,
    parameter int MIN_PERIOD_TICKS = 7,
    parameter bit PARK_UNUSED      = 1'b1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                line_req,
    input  logic [NUM_QUAD-1:0] quad_en,
    input  logic [DLY_W-1:0]    start_delay,
    input  logic [PIX_W-1:0]    pix_count,
    input  logic [TICK_W-1:0]   pix_period,
    input  logic [TICK_W-1:0]   rst_width,
    input  logic [TICK_W-1:0]   samp_rst_ofs,
    input  logic [TICK_W-1:0]   samp_vid_ofs,
    output logic [NUM_QUAD-1:0] h1_stor,
    output logic [NUM_QUAD-1:0] h1_barr,
    output logic [NUM_QUAD-1:0] h2_stor,
    output logic [NUM_QUAD-1:0] h2_barr,
    output logic [NUM_QUAD-1:0] h2_last,
    output logic [NUM_QUAD-1:0] reset_gate,
    output logic                samp_rst,
    output logic                samp_vid,
    output logic                line_done
);

    logic              run;
    logic              seq_done;
    logic [TICK_W-1:0] tick;
    logic [TICK_W-1:0] per;
    logic [TICK_W-1:0] rw;
    logic [TICK_W-1:0] srst;
    logic [TICK_W-1:0] svid;
    logic              h1_pat;
    logic              h2_pat;
    logic              rg_pat;

    hclk_seq #(
        .TICK_W           (TICK_W),
        .PIX_W            (PIX_W),
        .DLY_W            (DLY_W),
        .MIN_START_TICKS  (MIN_START_TICKS),
        .MIN_PERIOD_TICKS (MIN_PERIOD_TICKS)
    ) u_seq (
        .clk          (clk),
        .rst_n        (rst_n),
        .line_req     (line_req),
        .start_delay  (start_delay),
        .pix_count    (pix_count),
        .pix_period   (pix_period),
        .rst_width    (rst_width),
        .samp_rst_ofs (samp_rst_ofs),
        .samp_vid_ofs (samp_vid_ofs),
        .run          (run),
        .tick         (tick),
        .per          (per),
        .rw           (rw),
        .srst         (srst),
        .svid         (svid),
        .done         (seq_done)
    );

    hclk_phase #(
        .TICK_W (TICK_W)
    ) u_phase (
        .clk       (clk),
        .rst_n     (rst_n),
        .run       (run),
        .tick      (tick),
        .per       (per),
        .rw        (rw),
        .srst      (srst),
        .svid      (svid),
        .done_in   (seq_done),
        .h1_pat    (h1_pat),
        .h2_pat    (h2_pat),
        .rg_pat    (rg_pat),
        .samp_rst  (samp_rst),
        .samp_vid  (samp_vid),
        .line_done (line_done)
    );

    for (genvar g = 0; g < NUM_QUAD; g++) begin : g_quad
        hclk_quad #(
            .PARK_UNUSED (PARK_UNUSED)
        ) u_quad (
            .clk    (clk),
            .rst_n  (rst_n),
            .en     (quad_en[g]),
            .h1_pat (h1_pat),
            .h2_pat (h2_pat),
            .rg_pat (rg_pat),
            .h1s    (h1_stor[g]),
            .h1b    (h1_barr[g]),
            .h2s    (h2_stor[g]),
            .h2b    (h2_barr[g]),
            .h2l    (h2_last[g]),
            .rg     (reset_gate[g])
        );
    end

endmodule

// File: tb/hclk_gen_tb.sv
module hclk_gen_tb;

    localparam int NQ  = 4;
    localparam int VW  = 3 + 6 * NQ;
    localparam int MIN_D = 250;
    localparam int MIN_P = 7;

    typedef struct {
        logic [VW-1:0] v;
        string         tag;
    } item_t;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          line_req = 1'b0;
    logic [NQ-1:0] quad_en = '1;
    logic [15:0]   start_delay = '0;
    logic [13:0]   pix_count = '0;
    logic [7:0]    pix_period = '0;
    logic [7:0]    rst_width = '0;
    logic [7:0]    samp_rst_ofs = '0;
    logic [7:0]    samp_vid_ofs = '0;
    logic [NQ-1:0] h1_stor, h1_barr, h2_stor, h2_barr, h2_last, reset_gate;
    logic          samp_rst, samp_vid, line_done;

    item_t exp_q[$];
    int    vectors = 0;
    int    fails   = 0;
    bit    finished = 1'b0;

    always #2 clk = ~clk;

    hclk_gen u_dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .line_req     (line_req),
        .quad_en      (quad_en),
        .start_delay  (start_delay),
        .pix_count    (pix_count),
        .pix_period   (pix_period),
        .rst_width    (rst_width),
        .samp_rst_ofs (samp_rst_ofs),
        .samp_vid_ofs (samp_vid_ofs),
        .h1_stor      (h1_stor),
        .h1_barr      (h1_barr),
        .h2_stor      (h2_stor),
        .h2_barr      (h2_barr),
        .h2_last      (h2_last),
        .reset_gate   (reset_gate),
        .samp_rst     (samp_rst),
        .samp_vid     (samp_vid),
        .line_done    (line_done)
    );

    function automatic logic [VW-1:0] expv(bit act, int tk, bit dn, logic [NQ-1:0] qen,
                                           int p, int w, int ofr, int ofv);
        logic [NQ-1:0] a1, a2, ag;
        bit h1, rg;
        h1 = act ? (tk < p / 2) : 1'b1;
        rg = act && (tk < w);
        for (int q = 0; q < NQ; q++) begin
            a1[q] = qen[q] ? h1 : 1'b0;
            a2[q] = qen[q] ? !h1 : 1'b0;
            ag[q] = qen[q] ? rg : 1'b0;
        end
        return {dn, act && (tk == ofv), act && (tk == ofr), ag, a2, a2, a2, a1, a1};
    endfunction

    task automatic push(logic [VW-1:0] v, string tag);
        item_t it;
        it.v   = v;
        it.tag = tag;
        exp_q.push_back(it);
    endtask

    // Monitor: one expected vector per falling edge
    initial begin
        forever begin
            @(negedge clk);
            if (exp_q.size() > 0) begin
                item_t it;
                logic [VW-1:0] act, diff;
                string fld;
                it   = exp_q.pop_front();
                act  = {line_done, samp_vid, samp_rst, reset_gate, h2_last,
                        h2_barr, h2_stor, h1_barr, h1_stor};
                vectors++;
                if (act !== it.v) begin
                    diff = act ^ it.v;
                    if (diff[VW-1])                    fld = "R7";
                    else if (diff[VW-2 -: 2] != '0)    fld = "R6";
                    else if (diff[VW-4 -: NQ] != '0)   fld = "R5";
                    else                               fld = "R3";
                    fails++;
                    $display("FAIL %s (%s) act=%h exp=%h", it.tag, fld, act, it.v);
                end
            end
        end
    end

    task automatic run_line(int dly, int n, int per, int rw, int ofr, int ofv,
                            logic [NQ-1:0] qen, bit poke, string tag);
        int d, p, w;
        d = (dly < MIN_D) ? MIN_D : dly;
        p = (per < MIN_P) ? MIN_P : per;
        w = (rw == 0) ? 1 : ((rw >= p) ? p - 1 : rw);
        @(negedge clk);
        quad_en      = qen;
        start_delay  = 16'(dly);
        pix_count    = 14'(n);
        pix_period   = 8'(per);
        rst_width    = 8'(rw);
        samp_rst_ofs = 8'(ofr);
        samp_vid_ofs = 8'(ofv);
        @(negedge clk);
        line_req = 1'b1;
        @(posedge clk);
        #1;
        line_req = 1'b0;
        // R2: idle until tick 0 of the first pixel
        for (int j = 0; j <= d; j++) push(expv(0, 0, 0, qen, p, w, ofr, ofv), "R2");
        for (int t = 0; t < n * p; t++) push(expv(1, t % p, 0, qen, p, w, ofr, ofv), tag);
        push(expv(0, 0, 1, qen, p, w, ofr, ofv), "R7");
        push(expv(0, 0, 0, qen, p, w, ofr, ofv), "R7");
        if (poke) begin
            // R9: second request mid-line must not restart or extend the line
            repeat (d + p + 3) @(negedge clk);
            line_req = 1'b1;
            @(negedge clk);
            line_req = 1'b0;
        end
        wait (exp_q.size() == 0);
        @(negedge clk);
    endtask

    // Watchdog
    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            fails++;
            $display("FAIL watchdog (R7) act=hung exp=line_done");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(posedge clk);
        #1;
        // R1: idle phase after reset
        for (int j = 0; j < 4; j++) push(expv(0, 0, 0, 4'b1111, MIN_P, 1, 0, 0), "R1");
        wait (exp_q.size() == 0);

        // R3 R5 R6: basic line, short delay clamped up to the minimum
        run_line(10, 4, 10, 3, 4, 8, 4'b1111, 1'b0, "R3");
        // R4 R10: period clamp, width 0 -> 1, video strobe offset beyond period, two quads parked
        run_line(300, 3, 4, 0, 1, 20, 4'b0101, 1'b0, "R4");
        // R9 R5: overlapping request, width clamped to P-1
        run_line(0, 2, 12, 15, 0, 11, 4'b1111, 1'b1, "R9");

        // R8: zero pixel count is ignored
        @(negedge clk);
        pix_count = '0;
        line_req  = 1'b1;
        @(posedge clk);
        #1;
        line_req = 1'b0;
        for (int j = 0; j < 300; j++) push(expv(0, 0, 0, 4'b1111, MIN_P, 1, 0, 0), "R8");
        wait (exp_q.size() == 0);

        // R10: single pixel, upper quadrants parked
        run_line(260, 1, 9, 2, 3, 7, 4'b0011, 1'b0, "R10");

        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

endmodule